// File: doc/BRIEF.md
# Test Access Port Controller with System-Reset Pin Override

This block is a boundary-scan test access port for a chip whose I/O group is made of tristate-capable pins. A serial test port (test clock, mode select, data in, optional asynchronous test reset) walks a sixteen-state controller. Through that controller it loads an 8-bit instruction and shifts one of three data registers between the serial input and the serial output. The data registers are a boundary register built from three cells per pin, a fixed 32-bit identification register and a one-bit bypass register.

The decoder supports the mandatory instructions (BYPASS, SAMPLE/PRELOAD, EXTEST) and the optional CLAMP, HIGHZ and IDCODE. For each pin it produces a pad output value and a pad output enable. In functional mode these come from the core. Under the test instructions they come from the boundary update latches, or the enable is turned off.

The chip's active-low system reset always overrides scan control: while it is low every pad enable in the group is off, whatever the instruction and whatever the latches hold. Scan behaviour therefore matches the standard only while system reset is held high. A test run with system reset low must expect floating pins.

Top module: `scan_port_ctrl`

## Requirements
- R1: Five consecutive rising test-clock edges with the mode select high bring the controller to Test-Logic-Reset from any state, which makes IDCODE the active instruction.
- R2: A low level on trst_n immediately resets the controller to Test-Logic-Reset and makes IDCODE the active instruction. The identification register is then the one shifted in Shift-DR.
- R3: In Capture-IR the instruction shift register loads 8'hA5, whose two low bits are 01. That pattern is the first eight bits shifted out in Shift-IR, least significant bit first.
- R4: IDCODE shifts out the 32-bit identification value, least significant bit first, and that value's bit 0 is 1.
- R5: BYPASS (8'hFF) and every opcode without an assigned meaning select the one-bit bypass register. It captures 0, so the serial output is 0 followed by the serial input delayed by one clock.
- R6: SAMPLE/PRELOAD (8'h01) selects the boundary register. For pin i, Capture-DR loads bit 3i with pad_in[i], bit 3i+1 with core_out[i] and bit 3i+2 with core_oe[i]. Update-DR copies bit 3i+1 into the output latch and bit 3i+2 into the enable latch for pin i. The pins remain in functional mode.
- R7: EXTEST (8'h00) selects the boundary register and drives pad_out and pad_oe from the update latches.
- R8: CLAMP (8'h03) drives the pins from the update latches while the bypass register sits between tdi and tdo. A data-register scan under CLAMP leaves the latches unchanged.
- R9: HIGHZ (8'h04) turns off every pad_oe and selects the bypass register.
- R10: While sys_rst_n is low, every pad_oe is 0 under any instruction, including EXTEST and CLAMP.
- R11: tdo_en is 1 only in Shift-IR and Shift-DR, and tdo and tdo_en change only on the falling test-clock edge.
- R12: Under IDCODE, BYPASS, SAMPLE/PRELOAD and undefined opcodes, with sys_rst_n high, pad_out follows core_out and pad_oe follows core_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on rising tck |
| tdi | input | 1 | Serial test data in |
| sys_rst_n | input | 1 | Chip system reset, active low; forces pins to float |
| core_out | input | NPINS | Functional output values from the core |
| core_oe | input | NPINS | Functional output enables from the core |
| pad_in | input | NPINS | Values seen at the pads |
| tdo | output | 1 | Serial test data out, updated on falling tck |
| tdo_en | output | 1 | Output enable for tdo |
| pad_out | output | NPINS | Value driven to each pad |
| pad_oe | output | NPINS | Output enable for each pad |

## Verification
Most internal faults in this block show up on the serial output within one scan. A wrong controller state misaligns the captured bits or leaves tdo_en wrong in the very next shift. A bad instruction decode shows at once as a wrong pad drive, or as the wrong register length in the next data scan. Faults in the update latches only appear once EXTEST or CLAMP puts them on the pads, so the bench preloads random patterns and switches to those instructions right away. The reset override is checked on the pads within the same cycle that sys_rst_n falls.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int IR_W = 8;

    localparam logic [IR_W-1:0] OP_EXTEST  = 8'h00;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 8'h01;
    localparam logic [IR_W-1:0] OP_IDCODE  = 8'h02;
    localparam logic [IR_W-1:0] OP_CLAMP   = 8'h03;
    localparam logic [IR_W-1:0] OP_HIGHZ   = 8'h04;
    localparam logic [IR_W-1:0] OP_BYPASS  = 8'hFF;

    // pattern loaded in Capture-IR, low two bits fixed at 01
    localparam logic [IR_W-1:0] IR_CAPTURE = 8'hA5;

    typedef enum logic [3:0] {
        TS_RESET,
        TS_IDLE,
        TS_DR_SEL,
        TS_DR_CAP,
        TS_DR_SHIFT,
        TS_DR_EXIT1,
        TS_DR_PAUSE,
        TS_DR_EXIT2,
        TS_DR_UPD,
        TS_IR_SEL,
        TS_IR_CAP,
        TS_IR_SHIFT,
        TS_IR_EXIT1,
        TS_IR_PAUSE,
        TS_IR_EXIT2,
        TS_IR_UPD
    } tap_state_e;

    typedef enum logic [1:0] {
        DR_BYPASS,
        DR_IDCODE,
        DR_BOUNDARY
    } dr_sel_e;

    typedef enum logic [1:0] {
        PM_FUNC,
        PM_DRIVE,
        PM_FLOAT
    } pin_mode_e;

    typedef struct packed {
        dr_sel_e   dr;
        pin_mode_e pins;
        logic      bsr_upd;
    } instr_ctl_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            TS_RESET:    n = m ? TS_RESET    : TS_IDLE;
            TS_IDLE:     n = m ? TS_DR_SEL   : TS_IDLE;
            TS_DR_SEL:   n = m ? TS_IR_SEL   : TS_DR_CAP;
            TS_DR_CAP:   n = m ? TS_DR_EXIT1 : TS_DR_SHIFT;
            TS_DR_SHIFT: n = m ? TS_DR_EXIT1 : TS_DR_SHIFT;
            TS_DR_EXIT1: n = m ? TS_DR_UPD   : TS_DR_PAUSE;
            TS_DR_PAUSE: n = m ? TS_DR_EXIT2 : TS_DR_PAUSE;
            TS_DR_EXIT2: n = m ? TS_DR_UPD   : TS_DR_SHIFT;
            TS_DR_UPD:   n = m ? TS_DR_SEL   : TS_IDLE;
            TS_IR_SEL:   n = m ? TS_RESET    : TS_IR_CAP;
            TS_IR_CAP:   n = m ? TS_IR_EXIT1 : TS_IR_SHIFT;
            TS_IR_SHIFT: n = m ? TS_IR_EXIT1 : TS_IR_SHIFT;
            TS_IR_EXIT1: n = m ? TS_IR_UPD   : TS_IR_PAUSE;
            TS_IR_PAUSE: n = m ? TS_IR_EXIT2 : TS_IR_PAUSE;
            TS_IR_EXIT2: n = m ? TS_IR_UPD   : TS_IR_SHIFT;
            TS_IR_UPD:   n = m ? TS_DR_SEL   : TS_IDLE;
            default:     n = TS_RESET;
        endcase
        return n;
    endfunction

    function automatic instr_ctl_t decode_instr(input logic [IR_W-1:0] op);
        instr_ctl_t c;
        c = '{dr: DR_BYPASS, pins: PM_FUNC, bsr_upd: 1'b0};
        case (op)
            OP_EXTEST: c = '{dr: DR_BOUNDARY, pins: PM_DRIVE, bsr_upd: 1'b1};
            OP_SAMPLE: c = '{dr: DR_BOUNDARY, pins: PM_FUNC,  bsr_upd: 1'b1};
            OP_IDCODE: c = '{dr: DR_IDCODE,   pins: PM_FUNC,  bsr_upd: 1'b0};
            OP_CLAMP:  c = '{dr: DR_BYPASS,   pins: PM_DRIVE, bsr_upd: 1'b0};
            OP_HIGHZ:  c = '{dr: DR_BYPASS,   pins: PM_FLOAT, bsr_upd: 1'b0};
            default:   c = '{dr: DR_BYPASS,   pins: PM_FUNC,  bsr_upd: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_o
);

    typedef struct packed {
        tap_state_e st;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.st = tap_next(r_q.st, tms);
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{st: TS_RESET};
        else         r_q <= r_d;
    end

    assign state_o = r_q.st;

endmodule

// File: rtl/scan_ir.sv
module scan_ir
    import scan_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_state_e      state_i,
    output logic [IR_W-1:0] ir_cur_o,
    output logic [IR_W-1:0] ir_shift_o,
    output logic            ir_tdo_o
);

    typedef struct packed {
        logic [IR_W-1:0] sr;
        logic [IR_W-1:0] cur;
    } ir_regs_t;

    ir_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state_i)
            TS_RESET:    r_d.cur = OP_IDCODE;
            TS_IR_CAP:   r_d.sr  = IR_CAPTURE;
            TS_IR_SHIFT: r_d.sr  = {tdi, r_q.sr[IR_W-1:1]};
            TS_IR_UPD:   r_d.cur = r_q.sr;
            default:     ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{sr: IR_CAPTURE, cur: OP_IDCODE};
        else         r_q <= r_d;
    end

    assign ir_cur_o   = r_q.cur;
    assign ir_shift_o = r_q.sr;
    assign ir_tdo_o   = r_q.sr[0];

endmodule

// File: rtl/scan_dr.sv
module scan_dr
    import scan_pkg::*;
#(
    parameter int          NPINS      = 4,
    parameter logic [31:0] IDCODE_VAL = 32'h4C5B_1A37
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tdi,
    input  tap_state_e       state_i,
    input  dr_sel_e          dr_sel_i,
    input  logic             bsr_upd_i,
    input  logic [NPINS-1:0] pad_in_i,
    input  logic [NPINS-1:0] core_out_i,
    input  logic [NPINS-1:0] core_oe_i,
    output logic             dr_tdo_o,
    output logic [NPINS-1:0] upd_out_o,
    output logic [NPINS-1:0] upd_oe_o
);

    localparam int CELLS   = 3;
    localparam int BSR_LEN = CELLS * NPINS;
    localparam int ID_W    = 32;

    typedef struct packed {
        logic [BSR_LEN-1:0] bsr;
        logic [ID_W-1:0]    id;
        logic               byp;
        logic [NPINS-1:0]   lat_out;
        logic [NPINS-1:0]   lat_oe;
    } dr_regs_t;

    dr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state_i)
            TS_DR_CAP: begin
                case (dr_sel_i)
                    DR_BOUNDARY: begin
                        for (int i = 0; i < NPINS; i++) begin
                            r_d.bsr[CELLS*i]     = pad_in_i[i];
                            r_d.bsr[CELLS*i + 1] = core_out_i[i];
                            r_d.bsr[CELLS*i + 2] = core_oe_i[i];
                        end
                    end
                    DR_IDCODE: r_d.id  = IDCODE_VAL;
                    default:   r_d.byp = 1'b0;
                endcase
            end
            TS_DR_SHIFT: begin
                case (dr_sel_i)
                    DR_BOUNDARY: r_d.bsr = {tdi, r_q.bsr[BSR_LEN-1:1]};
                    DR_IDCODE:   r_d.id  = {tdi, r_q.id[ID_W-1:1]};
                    default:     r_d.byp = tdi;
                endcase
            end
            TS_DR_UPD: begin
                if (bsr_upd_i) begin
                    for (int i = 0; i < NPINS; i++) begin
                        r_d.lat_out[i] = r_q.bsr[CELLS*i + 1];
                        r_d.lat_oe[i]  = r_q.bsr[CELLS*i + 2];
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '0;
        else         r_q <= r_d;
    end

    always_comb begin
        case (dr_sel_i)
            DR_BOUNDARY: dr_tdo_o = r_q.bsr[0];
            DR_IDCODE:   dr_tdo_o = r_q.id[0];
            default:     dr_tdo_o = r_q.byp;
        endcase
    end

    assign upd_out_o = r_q.lat_out;
    assign upd_oe_o  = r_q.lat_oe;

endmodule

// File: rtl/scan_pin_cell.sv
module scan_pin_cell
    import scan_pkg::*;
(
    input  pin_mode_e mode_i,
    input  logic      sys_rst_n,
    input  logic      core_out_i,
    input  logic      core_oe_i,
    input  logic      upd_out_i,
    input  logic      upd_oe_i,
    output logic      pad_out_o,
    output logic      pad_oe_o
);

    logic oe_sel;

    always_comb begin
        case (mode_i)
            PM_DRIVE: begin
                pad_out_o = upd_out_i;
                oe_sel    = upd_oe_i;
            end
            PM_FLOAT: begin
                pad_out_o = core_out_i;
                oe_sel    = 1'b0;
            end
            default: begin
                pad_out_o = core_out_i;
                oe_sel    = core_oe_i;
            end
        endcase
        // system reset wins over every scan setting
        pad_oe_o = oe_sel & sys_rst_n;
    end

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
    import scan_pkg::*;
#(
    parameter int          NPINS      = 4,
    parameter logic [31:0] IDCODE_VAL = 32'h4C5B_1A37
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic             sys_rst_n,
    input  logic [NPINS-1:0] core_out,
    input  logic [NPINS-1:0] core_oe,
    input  logic [NPINS-1:0] pad_in,
    output logic             tdo,
    output logic             tdo_en,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);

    tap_state_e      tap_state;
    logic [IR_W-1:0] ir_cur;
    logic [IR_W-1:0] ir_shift;
    logic            ir_tdo;
    logic            dr_tdo;
    instr_ctl_t      ctl;
    logic [NPINS-1:0] upd_out;
    logic [NPINS-1:0] upd_oe;

    scan_tap_fsm u_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_o (tap_state)
    );

    scan_ir u_ir (
        .tck        (tck),
        .trst_n     (trst_n),
        .tdi        (tdi),
        .state_i    (tap_state),
        .ir_cur_o   (ir_cur),
        .ir_shift_o (ir_shift),
        .ir_tdo_o   (ir_tdo)
    );

    always_comb ctl = decode_instr(ir_cur);

    scan_dr #(
        .NPINS      (NPINS),
        .IDCODE_VAL (IDCODE_VAL)
    ) u_dr (
        .tck        (tck),
        .trst_n     (trst_n),
        .tdi        (tdi),
        .state_i    (tap_state),
        .dr_sel_i   (ctl.dr),
        .bsr_upd_i  (ctl.bsr_upd),
        .pad_in_i   (pad_in),
        .core_out_i (core_out),
        .core_oe_i  (core_oe),
        .dr_tdo_o   (dr_tdo),
        .upd_out_o  (upd_out),
        .upd_oe_o   (upd_oe)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        scan_pin_cell u_cell (
            .mode_i     (ctl.pins),
            .sys_rst_n  (sys_rst_n),
            .core_out_i (core_out[g]),
            .core_oe_i  (core_oe[g]),
            .upd_out_i  (upd_out[g]),
            .upd_oe_i   (upd_oe[g]),
            .pad_out_o  (pad_out[g]),
            .pad_oe_o   (pad_oe[g])
        );
    end

    // serial output retimed to the falling test-clock edge
    typedef struct packed {
        logic tdo;
        logic en;
    } tdo_regs_t;

    tdo_regs_t t_d, t_q;

    always_comb begin
        t_d.en  = (tap_state == TS_IR_SHIFT) || (tap_state == TS_DR_SHIFT);
        t_d.tdo = (tap_state == TS_IR_SHIFT) ? ir_tdo : dr_tdo;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) t_q <= '0;
        else         t_q <= t_d;
    end

    assign tdo    = t_q.tdo;
    assign tdo_en = t_q.en;

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
    import scan_pkg::*;
#(
    parameter int NPINS = 4
) (
    input logic             tck,
    input logic             trst_n,
    input logic             sys_rst_n,
    input tap_state_e       tap_state,
    input logic [IR_W-1:0]  ir_cur,
    input logic [IR_W-1:0]  ir_shift,
    input logic [NPINS-1:0] upd_out,
    input logic [NPINS-1:0] upd_oe,
    input logic [NPINS-1:0] core_out,
    input logic [NPINS-1:0] core_oe,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic             tdo_en
);

    // R1 R2
    ir_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tap_state == TS_RESET |=> ir_cur == OP_IDCODE);

    // R3
    ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tap_state == TS_IR_CAP |=> ir_shift == IR_CAPTURE);

    // R10
    rst_float_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !sys_rst_n |-> pad_oe == '0);

    // R9
    highz_chk: assert property (@(posedge tck) disable iff (!trst_n)
        ir_cur == OP_HIGHZ |-> pad_oe == '0);

    // R8
    clamp_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (sys_rst_n && ir_cur == OP_CLAMP) |-> (pad_out == upd_out && pad_oe == upd_oe));

    // R8
    clamp_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (ir_cur == OP_CLAMP && $past(ir_cur) == OP_CLAMP) |-> $stable(upd_out) && $stable(upd_oe));

    // R12
    func_pass_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (sys_rst_n && ir_cur != OP_EXTEST && ir_cur != OP_CLAMP && ir_cur != OP_HIGHZ)
        |-> (pad_out == core_out && pad_oe == core_oe));

    // R11
    tdo_window_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en == (tap_state == TS_IR_SHIFT || tap_state == TS_DR_SHIFT));

endmodule

bind scan_port_ctrl scan_port_chk #(.NPINS(NPINS)) u_chk (
    .tck       (tck),
    .trst_n    (trst_n),
    .sys_rst_n (sys_rst_n),
    .tap_state (tap_state),
    .ir_cur    (ir_cur),
    .ir_shift  (ir_shift),
    .upd_out   (upd_out),
    .upd_oe    (upd_oe),
    .core_out  (core_out),
    .core_oe   (core_oe),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .tdo_en    (tdo_en)
);

// File: tb/scan_port_ctrl_tb.sv
module scan_port_ctrl_tb;
    import scan_pkg::*;

    localparam int          NP = 4;
    localparam int          BL = 3 * NP;
    localparam logic [31:0] ID = 32'h4C5B_1A37;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic sys_rst_n = 1'b1;
    logic [NP-1:0] core_out = '0;
    logic [NP-1:0] core_oe = '0;
    logic [NP-1:0] pad_in = '0;
    logic tdo, tdo_en;
    logic [NP-1:0] pad_out, pad_oe;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [NP-1:0] lat_out = '0;
    logic [NP-1:0] lat_oe = '0;
    logic [7:0] cur_op = OP_IDCODE;
    logic en_ok;

    always #4 tck = ~tck;

    scan_port_ctrl #(.NPINS(NP), .IDCODE_VAL(ID)) u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .sys_rst_n(sys_rst_n),
        .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
        .tdo(tdo), .tdo_en(tdo_en), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one test clock: sample tdo (valid since last falling edge), drive, advance
    task automatic step(input logic m, input logic d, output logic o, output logic e);
        o = tdo;
        e = tdo_en;
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic shift_ir(input logic [7:0] op, output logic [7:0] cap);
        logic o, e;
        en_ok = 1'b1;
        step(1, 0, o, e); step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
        for (int i = 0; i < 8; i++) begin
            step(i == 7, op[i], o, e);
            cap[i] = o;
            if (e !== 1'b1) en_ok = 1'b0;
        end
        step(1, 0, o, e); step(0, 0, o, e);
        cur_op = op;
    endtask

    task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic o, e;
        en_ok = 1'b1;
        dout = '0;
        step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o, e);
            dout[i] = o;
            if (e !== 1'b1) en_ok = 1'b0;
        end
        step(1, 0, o, e); step(0, 0, o, e);
        if (cur_op == OP_EXTEST || cur_op == OP_SAMPLE) begin
            for (int i = 0; i < NP; i++) begin
                lat_out[i] = din[3*i + 1];
                lat_oe[i]  = din[3*i + 2];
            end
        end
    endtask

    function automatic logic [BL-1:0] exp_capture();
        logic [BL-1:0] v;
        for (int i = 0; i < NP; i++) begin
            v[3*i]     = pad_in[i];
            v[3*i + 1] = core_out[i];
            v[3*i + 2] = core_oe[i];
        end
        return v;
    endfunction

    task automatic check_pins(input string req);
        logic [NP-1:0] eo, eoe;
        case (cur_op)
            OP_EXTEST, OP_CLAMP: begin eo = lat_out;  eoe = lat_oe; end
            OP_HIGHZ:            begin eo = core_out; eoe = '0;     end
            default:             begin eo = core_out; eoe = core_oe; end
        endcase
        if (!sys_rst_n) eoe = '0;
        chk(pad_out === eo && pad_oe === eoe, req, {pad_out, pad_oe}, {eo, eoe});
    endtask

    task automatic rand_pins();
        core_out = NP'($urandom());
        core_oe  = NP'($urandom());
        pad_in   = NP'($urandom());
        #1;
    endtask

    task automatic check_bypass(input string req);
        logic [63:0] din, dout, exp;
        din = {48'h0, 16'($urandom())};
        shift_dr(16, din, dout);
        exp = {48'h0, din[14:0], 1'b0};
        chk(dout[15:0] === exp[15:0] && en_ok, req, dout[15:0], exp[15:0]);
    endtask

    task automatic check_idcode(input string req);
        logic [63:0] dout;
        shift_dr(32, 64'h0, dout);
        chk(dout[31:0] === ID && dout[0] === 1'b1 && en_ok, req, dout[31:0], ID);
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] cap;
        logic [63:0] din, dout;
        logic o, e, v0, v1, v2;
        void'($urandom(32'd2024));

        @(negedge tck); #1;
        trst_n = 1'b1;
        rand_pins();

        // reset state: serial output disabled, pins functional (R11, R12)
        chk(tdo_en === 1'b0, "R11 reset tdo_en", tdo_en, 0);
        check_pins("R12 reset pins functional");
        step(0, 0, o, e);
        check_idcode("R2 R4 idcode after reset");

        // instruction capture pattern (R3)
        shift_ir(OP_BYPASS, cap);
        chk(cap === IR_CAPTURE && cap[1:0] === 2'b01 && en_ok, "R3 capture-ir", cap, IR_CAPTURE);
        chk(tdo_en === 1'b0, "R11 tdo_en off in idle", tdo_en, 0);
        check_bypass("R5 bypass opcode");

        // undefined opcodes act as bypass (R5)
        for (int k = 0; k < 4; k++) begin
            shift_ir(8'($urandom_range(5, 254)), cap);
            check_bypass("R5 undefined opcode");
            check_pins("R12 undefined opcode pins functional");
        end

        // sample / preload (R6)
        for (int k = 0; k < 3; k++) begin
            shift_ir(OP_SAMPLE, cap);
            rand_pins();
            check_pins("R6 R12 sample keeps pins functional");
            din = {52'h0, 12'($urandom())};
            shift_dr(BL, din, dout);
            chk(dout[BL-1:0] === exp_capture() && en_ok, "R6 boundary capture", dout[BL-1:0], exp_capture());
        end

        // extest drives latches (R7) and system reset floats them (R10)
        shift_ir(OP_EXTEST, cap);
        check_pins("R7 extest drives preload");
        rand_pins();
        din = {52'h0, 12'($urandom())};
        shift_dr(BL, din, dout);
        chk(dout[BL-1:0] === exp_capture(), "R7 extest capture", dout[BL-1:0], exp_capture());
        check_pins("R7 extest drives new update");
        sys_rst_n = 1'b0; #1;
        check_pins("R10 reset floats extest");
        sys_rst_n = 1'b1; #1;
        check_pins("R7 extest after reset release");

        // clamp (R8)
        din = {52'h0, 12'hFFF};
        shift_ir(OP_SAMPLE, cap);
        shift_dr(BL, din, dout);
        shift_ir(OP_CLAMP, cap);
        check_pins("R8 clamp drives latches");
        check_bypass("R8 clamp selects bypass");
        check_pins("R8 clamp latches unchanged by scan");
        sys_rst_n = 1'b0; #1;
        check_pins("R10 reset floats clamp");
        sys_rst_n = 1'b1; #1;

        // highz (R9)
        shift_ir(OP_HIGHZ, cap);
        rand_pins();
        core_oe = '1; #1;
        check_pins("R9 highz floats pins");
        check_bypass("R9 highz selects bypass");

        // five tms-high clocks from Shift-DR (R1)
        shift_ir(OP_EXTEST, cap);
        step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
        for (int k = 0; k < 5; k++) step(1, 0, o, e);
        step(0, 0, o, e);
        cur_op = OP_IDCODE;
        check_pins("R1 reset from shift-dr");
        check_idcode("R1 idcode after tms reset");

        // five tms-high clocks from Pause-IR (R1)
        shift_ir(OP_HIGHZ, cap);
        step(1, 0, o, e); step(1, 0, o, e); step(0, 0, o, e); step(1, 0, o, e); step(0, 0, o, e);
        for (int k = 0; k < 5; k++) step(1, 0, o, e);
        step(0, 0, o, e);
        cur_op = OP_IDCODE;
        check_pins("R1 reset from pause-ir");

        // tdo changes only on falling edge (R11)
        step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
        v0 = tdo;
        tms = 1'b0;
        @(posedge tck); #1;
        v1 = tdo;
        chk(v1 === v0 && v0 === ID[0], "R11 tdo stable across rising edge", {v0, v1}, {ID[0], ID[0]});
        @(negedge tck); #1;
        v2 = tdo;
        chk(v2 === ID[1] && tdo_en === 1'b1, "R11 tdo updates on falling edge", v2, ID[1]);
        step(1, 0, o, e); step(1, 0, o, e); step(0, 0, o, e);

        // asynchronous test reset mid-scan (R2)
        shift_ir(OP_EXTEST, cap);
        step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
        trst_n = 1'b0; #1;
        cur_op = OP_IDCODE;
        chk(tdo_en === 1'b0, "R2 trst clears tdo_en", tdo_en, 0);
        check_pins("R2 trst returns pins functional");
        trst_n = 1'b1;
        step(0, 0, o, e);
        check_idcode("R2 idcode after trst");

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule